// File: doc/BRIEF.md
# Nine-bit serial receiver with slave address filtering

This block is the receive half of an asynchronous serial port that carries nine-bit frames on a shared multidrop line. It recovers each frame from the line using a 16x oversampling tick. It then decides whether the frame is meant for this node. When address filtering is on, only address frames (ninth bit set) whose byte hits either the node's masked own address or its derived broadcast address are passed on. When filtering is off, every well-formed frame is passed on, so that software can take the data bytes that follow a successful address hit.

The node address and the address mask are plain configuration inputs. A 1 in the mask makes the corresponding address bit take part in the comparison, and a 0 makes it don't-care. The broadcast pattern is the bitwise OR of address and mask: positions where it is 1 must be received as 1, and positions where it is 0 are ignored. Accepted frames load the output byte and ninth-bit registers and set a sticky interrupt flag, which software drops with a one-cycle clear pulse.

Top module: `mpu_rx_filter`

## Requirements
- R1: A frame is a low start bit, eight data bits with the least significant bit first, a ninth bit, and a high stop bit, each 16 ticks long. Each bit is sampled near its middle, and an accepted frame shows its byte on `rx_byte` and its ninth bit on `rx_bit9`.
- R2: With `addr_mode` at 0, every frame with a valid stop bit is accepted, whatever its ninth bit.
- R3: With `addr_mode` at 1 and the ninth bit at 1, a byte is accepted when it equals `node_addr` in every bit position where `addr_mask` is 1. Bits where the mask is 0 are ignored.
- R4: With `addr_mode` at 1 and the ninth bit at 1, a byte is accepted when it has a 1 in every position where `node_addr | addr_mask` is 1. As a result, 0xFF is always accepted.
- R5: With `addr_mode` at 1, a frame with its ninth bit at 1 that meets neither R3 nor R4 is dropped. No interrupt is raised and the outputs keep their values.
- R6: With `addr_mode` at 1, a frame whose ninth bit is 0 is dropped.
- R7: `rx_byte` and `rx_bit9` change only when a frame is accepted.
- R8: `rx_irq` is set by an accepted frame and stays set until `irq_clr` is pulsed. It is low in the cycle after the clear, unless a frame is accepted in that same cycle.
- R9: A frame whose stop bit samples low is dropped, and the receiver waits for the line to return high before it looks for a new start edge.
- R10: A low pulse shorter than half a bit period is rejected as a false start, and no frame results.
- R11: After reset, `rx_byte` is 0x00, `rx_bit9` is 0 and `rx_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Serial input, idles high; asynchronous to `clk` |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| node_addr | input | 8 | Node address |
| addr_mask | input | 8 | Address compare mask; a 1 means the bit is compared |
| addr_mode | input | 1 | 1 enables address filtering |
| irq_clr | input | 1 | One-cycle pulse that clears `rx_irq` |
| rx_byte | output | 8 | Byte of the last accepted frame |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_irq | output | 1 | Sticky receive interrupt flag |

## Verification
The assertions assume that `tick16` arrives no more often than every other clock. They also assume that `node_addr`, `addr_mask` and `addr_mode` do not change while a frame is in flight, since the compare uses their values at the stop bit. The stimulus pulses the tick every second cycle, changes the configuration only while the line is idle between frames, and sends every edge on a bit boundary that is 32 clocks wide. The only exception is the deliberate short glitch, which stays well below half a bit.

// File: rtl/mpu_rx_pkg.sv
// Shared types for the nine-bit filtered receiver.
// Assumes a fixed eight-bit payload plus one ninth bit per frame.
package mpu_rx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ninth;
        logic              stop_ok;
    } rx_frame_t;
endpackage

// File: rtl/mpu_rx_sync.sv
// Brings the asynchronous serial line into the clock domain.
// Assumes the line idles high; the reset value matches idle.
module mpu_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpu_rx_frame.sv
// Recovers one nine-bit frame from the synchronized line.
// Looks for a falling edge, confirms the start bit at mid-bit, and samples
// each further bit OVS ticks later. At the stop bit it emits a one-cycle
// done pulse with the frame contents. Assumes tick is a single-cycle strobe.
module mpu_rx_frame
    import mpu_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW    = $clog2(OVS);
    localparam int MID   = OVS / 2 - 1;
    localparam int LAST  = OVS - 1;
    localparam int NBITS = DATA_W + 1;
    localparam int IW    = $clog2(NBITS + 1);

    rx_state_t       state;
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   idx;
    logic [NBITS-1:0] shreg;
    logic            prev;
    logic            fall;

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= line;
    end

    assign fall = prev & ~line;

    // Frame state machine: start hunt, start check, bit sampling, stop sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (fall) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (cnt == CW'(MID)) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= line ? ST_IDLE : ST_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_BITS: begin
                    if (tick) begin
                        if (cnt == CW'(LAST)) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[NBITS-1:1]};
                            if (idx == IW'(NBITS - 1)) state <= ST_STOP;
                            else                       idx   <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (cnt == CW'(LAST)) begin
                            cnt           <= '0;
                            done          <= 1'b1;
                            frame.data    <= shreg[DATA_W-1:0];
                            frame.ninth   <= shreg[NBITS-1];
                            frame.stop_ok <= line;
                            state         <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mpu_addr_match.sv
// Compares a received byte with the node's masked address and with the
// broadcast pattern (address OR mask). Purely combinational.
module mpu_addr_match
    import mpu_rx_pkg::*;
(
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] data,
    output logic              ind_hit,
    output logic              bc_hit
);
    logic [DATA_W-1:0] ind_ok;
    logic [DATA_W-1:0] bc_ok;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign ind_ok[i] = ~mask[i] | (data[i] == addr[i]);
        assign bc_ok[i]  = ~(addr[i] | mask[i]) | data[i];
    end

    assign ind_hit = &ind_ok;
    assign bc_hit  = &bc_ok;
endmodule

// File: rtl/mpu_rx_filter.sv
// Top of the filtered nine-bit receiver. Chains synchronizer, frame
// recovery and address matching, then holds the accepted byte, ninth bit
// and a sticky interrupt flag. Assumes configuration is steady during a frame.
module mpu_rx_filter
    import mpu_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tick16,
    input  logic [DATA_W-1:0] node_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              addr_mode,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_irq
);
    logic      line_s;
    logic      fr_done;
    rx_frame_t fr;
    logic      ind_hit;
    logic      bc_hit;
    logic      frame_accept;

    mpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    mpu_rx_frame #(.OVS(OVS)) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick16),
        .line (line_s),
        .done (fr_done),
        .frame(fr)
    );

    mpu_addr_match u_match (
        .addr   (node_addr),
        .mask   (addr_mask),
        .data   (fr.data),
        .ind_hit(ind_hit),
        .bc_hit (bc_hit)
    );

    // Decide whether the finished frame is passed on.
    always_comb begin
        frame_accept = fr_done & fr.stop_ok;
        if (addr_mode) frame_accept = frame_accept & fr.ninth & (ind_hit | bc_hit);
    end

    // Hold the accepted frame contents and the sticky interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rx_bit9 <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            if (frame_accept) begin
                rx_byte <= fr.data;
                rx_bit9 <= fr.ninth;
                rx_irq  <= 1'b1;
            end else if (irq_clr) begin
                rx_irq  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mpu_rx_filter_chk.sv
// Property checker for the filtered receiver, attached through bind.
module mpu_rx_filter_chk
    import mpu_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] node_addr,
    input logic [DATA_W-1:0] addr_mask,
    input logic              addr_mode,
    input logic              irq_clr,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_bit9,
    input logic              rx_irq,
    input logic              frame_accept,
    input rx_frame_t         fr
);
    // R8: flag persists without a clear
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !irq_clr) |=> rx_irq);

    // R8: a clear with no new frame drops the flag
    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !frame_accept) |=> !rx_irq);

    // R7: outputs hold unless a frame is accepted
    assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_accept |=> ($stable(rx_byte) && $stable(rx_bit9)));

    // R7: a rising flag always follows an acceptance
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(frame_accept));

    // R6: filtered acceptance needs the ninth bit
    assert_ninth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_accept && addr_mode) |-> fr.ninth);

    // R3 and R4: filtered acceptance needs an address hit
    assert_addr_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_accept && addr_mode) |->
            ((((fr.data ^ node_addr) & addr_mask) == '0) ||
             ((fr.data & (node_addr | addr_mask)) == (node_addr | addr_mask))));

    // R9: a bad stop bit never passes
    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_accept |-> fr.stop_ok);

    // R11: reset clears the flag
    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (!rx_irq && rx_byte == '0 && !rx_bit9));
endmodule

bind mpu_rx_filter mpu_rx_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .node_addr   (node_addr),
    .addr_mask   (addr_mask),
    .addr_mode   (addr_mode),
    .irq_clr     (irq_clr),
    .rx_byte     (rx_byte),
    .rx_bit9     (rx_bit9),
    .rx_irq      (rx_irq),
    .frame_accept(frame_accept),
    .fr          (fr)
);

// File: tb/sim_mpu_rx_filter.sv
// Scoreboard bench: the driver queues expected frames, the monitor pops
// them when the interrupt rises and then clears it.
module sim_mpu_rx_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       tick16 = 1'b0;
    logic [7:0] node_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       addr_mode = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_irq;

    int errors = 0;
    int checks = 0;
    logic [8:0] exp_q[$];
    logic [7:0] last_byte = 8'h00;
    logic       last_b9 = 1'b0;

    localparam int BIT_CLK = 32;

    always #4 clk = ~clk;

    mpu_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .node_addr(node_addr), .addr_mask(addr_mask), .addr_mode(addr_mode),
        .irq_clr(irq_clr), .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_irq(rx_irq)
    );

    // Tick every other clock.
    initial forever begin
        @(negedge clk);
        tick16 = ~tick16;
    end

    task automatic chk(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Acceptance rule worked bit by bit from the requirements.
    function automatic logic exp_accept(input logic [7:0] d, input logic b9,
                                        input logic stop_ok);
        logic ind = 1'b1;
        logic bc  = 1'b1;
        if (!stop_ok) return 1'b0;
        if (!addr_mode) return 1'b1;
        if (!b9) return 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (addr_mask[i] && d[i] != node_addr[i]) ind = 1'b0;
            if ((node_addr[i] || addr_mask[i]) && !d[i]) bc = 1'b0;
        end
        return ind | bc;
    endfunction

    task automatic line_bit(input logic v);
        rx_line = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop_ok,
                              input string req);
        logic acc;
        acc = exp_accept(d, b9, stop_ok);
        if (acc) begin
            exp_q.push_back({b9, d});
            last_byte = d;
            last_b9   = b9;
        end
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        line_bit(b9);
        line_bit(stop_ok);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
        if (!acc)
            chk(rx_byte == last_byte && rx_bit9 == last_b9 && !rx_irq, req,
                {6'd0, rx_irq, rx_bit9, rx_byte}, {7'd0, last_b9, last_byte});
    endtask

    // Monitor: compare on each rising interrupt, verify it holds, then clear.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_irq) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected interrupt", {7'd0, rx_bit9, rx_byte}, 16'h0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({rx_bit9, rx_byte} == e, "R1 accepted frame contents",
                        {7'd0, rx_bit9, rx_byte}, {7'd0, e});
                end
                repeat (3) @(negedge clk);
                chk(rx_irq, "R8 flag held before clear", {15'd0, rx_irq}, 16'd1);
                irq_clr = 1'b1;
                @(negedge clk);
                irq_clr = 1'b0;
                chk(!rx_irq, "R8 flag dropped after clear", {15'd0, rx_irq}, 16'd0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_byte == 8'h00, "R11 reset byte", {8'd0, rx_byte}, 16'h0);
        chk(!rx_bit9, "R11 reset ninth bit", {15'd0, rx_bit9}, 16'h0);
        chk(!rx_irq, "R11 reset flag", {15'd0, rx_irq}, 16'h0);
        repeat (10) @(negedge clk);

        // R1, R2: unfiltered reception of both ninth-bit values
        send_frame(8'hA5, 1'b0, 1'b1, "R2");
        send_frame(8'h3C, 1'b1, 1'b1, "R2");

        // Node 1: address 0x35, mask 0x0F
        addr_mode = 1'b1; node_addr = 8'h35; addr_mask = 8'h0F;
        send_frame(8'hF5, 1'b1, 1'b1, "R3");
        send_frame(8'hF4, 1'b1, 1'b1, "R5 no match dropped");
        send_frame(8'hF5, 1'b0, 1'b1, "R6 ninth bit zero dropped");
        send_frame(8'h3F, 1'b1, 1'b1, "R4");
        send_frame(8'hFF, 1'b1, 1'b1, "R4");

        // Node 2: mask 0xF3
        addr_mask = 8'hF3;
        send_frame(8'h31, 1'b1, 1'b1, "R3");
        send_frame(8'h39, 1'b1, 1'b1, "R3");
        send_frame(8'hF7, 1'b1, 1'b1, "R4");
        send_frame(8'h75, 1'b1, 1'b1, "R5 no match dropped");

        // Node 3: mask 0xC0
        addr_mask = 8'hC0;
        send_frame(8'h0A, 1'b1, 1'b1, "R3");
        send_frame(8'hF5, 1'b1, 1'b1, "R4");
        send_frame(8'hB5, 1'b1, 1'b1, "R5 no match dropped");
        send_frame(8'h15, 1'b0, 1'b1, "R6 ninth bit zero dropped");

        // R9: bad stop bit
        addr_mode = 1'b0;
        send_frame(8'h55, 1'b0, 1'b0, "R9 bad stop dropped");

        // R10: short glitch rejected
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (BIT_CLK * 12) @(negedge clk);
        chk(!rx_irq && rx_byte == last_byte, "R10 glitch ignored",
            {7'd0, rx_irq, rx_byte}, {8'd0, last_byte});

        // R2: data byte after address phase
        send_frame(8'h00, 1'b0, 1'b1, "R2");
        send_frame(8'hC3, 1'b1, 1'b1, "R7");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all expected frames seen",
            16'(exp_q.size()), 16'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule